// File: doc/BRIEF.md
# Double-Buffered Auxiliary Control Register

This block holds an 8-bit control word for the auxiliary features of a frequency synthesizer. The word can be written in two ways. In serial mode it is shifted in one bit at a time over the same data and clock pins that program the counters. In parallel mode it is written from an 8-bit data bus. Serial bits first collect in a staging register. A separate output buffer takes them only on the commit event, so the decoded controls never change while a word is being shifted.

Five decoded controls come out of the buffer: power-down, counter load, main-select output routing, prescaler output routing, and a reference/divider output enable. An active-low enable input gates all five. The three upper bits of the word are reserved. They are stored and visible on the word output, but they drive no control.

All strobes (`wr_strobe`, `sclk`) are treated as signals synchronous to `clk`. Their edges are found by comparing each sample with the one taken on the previous clock.

Top module: `enh_ctrl_reg`

## Requirements
- R1: In serial mode (`direct_mode`=0, `serial_sel`=1), each detected rising edge of `sclk` shifts `sdata` into the staging register while `wr_strobe`=1 and `cnt_wr`=0. The first bit shifted ends up in `ctrl_word[7]` after eight shifts.
- R2: `ctrl_word` changes only on a commit event (R3 or R5). It holds its value while bits are shifting.
- R3: In serial mode, a falling edge of `wr_strobe` copies the staging register into `ctrl_word`. The copy is visible one clock after the edge is sampled.
- R4: A serial-mode falling edge of `wr_strobe` with no shifts since the previous commit commits the unchanged staging contents again.
- R5: In parallel mode (`direct_mode`=0, `serial_sel`=0), a rising edge of `wr_strobe` loads `pdata` into `ctrl_word`, with `pdata[7]` going to `ctrl_word[7]`.
- R6: While `enh_n`=0, the outputs follow the word bits: `pwr_down`=`ctrl_word[4]`, `cnt_load`=`ctrl_word[3]`, `msel_route`=`ctrl_word[2]`, `pre_route`=`ctrl_word[1]`, `fout_oe`=`ctrl_word[0]`.
- R7: While `enh_n`=1, all five decoded outputs are 0, whatever `ctrl_word` holds.
- R8: While `direct_mode`=1, neither the staging register nor `ctrl_word` changes.
- R9: No shift occurs while `cnt_wr`=1 or while `wr_strobe`=0.
- R10: Reset clears the staging register and `ctrl_word`. The reserved bits `ctrl_word[7:5]` are stored and shown on `ctrl_word`, but they affect no decoded output.
- R11: A rising edge of `wr_strobe` in serial mode does not load `pdata`. A falling edge in parallel mode does not commit the staging register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| direct_mode | input | 1 | 1 = direct pin mode, register frozen |
| serial_sel | input | 1 | 1 = serial loading, 0 = parallel loading |
| wr_strobe | input | 1 | Write strobe for this register |
| cnt_wr | input | 1 | Counter-word write strobe; high blocks shifting |
| sdata | input | 1 | Serial data bit |
| sclk | input | 1 | Serial shift clock, sampled on `clk` |
| pdata | input | 8 | Parallel data bus |
| enh_n | input | 1 | Active-low enable for the decoded controls |
| ctrl_word | output | 8 | Buffered control word |
| pwr_down | output | 1 | Power-down control |
| cnt_load | output | 1 | Counter load control |
| msel_route | output | 1 | Main-select output routing |
| pre_route | output | 1 | Prescaler output routing |
| fout_oe | output | 1 | Reference/divider output enable |

## Verification
On every clock, the assertions check four things:
- The word holds whenever no commit event was sampled.
- The word stays frozen in direct mode.
- A parallel write lands the bus value one clock later.
- The decoded outputs follow the word, or are held low while the enable is off.

The staging contents can only be seen once they are committed. For that reason, MSB-first ordering, blocking by the counter strobe, and re-committing an untouched stage are shown only by the bench's scenarios, which commit and compare against a model.

// File: rtl/enh_pkg.sv
package enh_pkg;
    localparam int CTRL_W = 8;
    // bit positions within the word (index 7 is the first serial bit)
    localparam int PWR_BIT  = 4;
    localparam int LOAD_BIT = 3;
    localparam int MSEL_BIT = 2;
    localparam int PRE_BIT  = 1;
    localparam int OE_BIT   = 0;

    typedef struct packed {
        logic [CTRL_W-1:0] stage;
        logic [CTRL_W-1:0] word;
    } enh_state_t;

    typedef struct packed {
        logic pwr_down;
        logic cnt_load;
        logic msel_route;
        logic pre_route;
        logic fout_oe;
    } enh_ctrl_t;
endpackage

// File: rtl/enh_edge_det.sv
module enh_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] = sig[i] & ~prev_q[i];
        assign fall[i] = ~sig[i] & prev_q[i];
    end
endmodule

// File: rtl/enh_decode.sv
module enh_decode
    import enh_pkg::*;
(
    input  logic [CTRL_W-1:0] word,
    input  logic              enh_n,
    output enh_ctrl_t         ctrl
);
    always_comb begin
        ctrl = '0;
        if (!enh_n) begin
            ctrl.pwr_down   = word[PWR_BIT];
            ctrl.cnt_load   = word[LOAD_BIT];
            ctrl.msel_route = word[MSEL_BIT];
            ctrl.pre_route  = word[PRE_BIT];
            ctrl.fout_oe    = word[OE_BIT];
        end
    end
endmodule

// File: rtl/enh_ctrl_reg.sv
module enh_ctrl_reg
    import enh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              direct_mode,
    input  logic              serial_sel,
    input  logic              wr_strobe,
    input  logic              cnt_wr,
    input  logic              sdata,
    input  logic              sclk,
    input  logic [CTRL_W-1:0] pdata,
    input  logic              enh_n,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic              pwr_down,
    output logic              cnt_load,
    output logic              msel_route,
    output logic              pre_route,
    output logic              fout_oe
);
    localparam int WR_IDX = 1;
    localparam int SC_IDX = 0;

    enh_state_t st_d, st_q;
    enh_ctrl_t  ctrl;
    logic [1:0] rise, fall;
    logic       ser_mode, par_mode, shift_en;

    enh_edge_det #(.N(2)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({wr_strobe, sclk}),
        .rise  (rise),
        .fall  (fall)
    );

    always_comb begin
        ser_mode = !direct_mode &&  serial_sel;
        par_mode = !direct_mode && !serial_sel;
        shift_en = ser_mode && wr_strobe && !cnt_wr && rise[SC_IDX];
        st_d = st_q;
        if (shift_en)
            st_d.stage = {st_q.stage[CTRL_W-2:0], sdata};
        if (ser_mode && fall[WR_IDX])
            st_d.word = st_q.stage;
        else if (par_mode && rise[WR_IDX])
            st_d.word = pdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    enh_decode dec_i (
        .word  (st_q.word),
        .enh_n (enh_n),
        .ctrl  (ctrl)
    );

    assign ctrl_word  = st_q.word;
    assign pwr_down   = ctrl.pwr_down;
    assign cnt_load   = ctrl.cnt_load;
    assign msel_route = ctrl.msel_route;
    assign pre_route  = ctrl.pre_route;
    assign fout_oe    = ctrl.fout_oe;
endmodule

// File: rtl/enh_ctrl_reg_chk.sv
module enh_ctrl_reg_chk
    import enh_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              direct_mode,
    input logic              serial_sel,
    input logic              wr_strobe,
    input logic [CTRL_W-1:0] pdata,
    input logic              enh_n,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              pwr_down,
    input logic              cnt_load,
    input logic              msel_route,
    input logic              pre_route,
    input logic              fout_oe
);
    logic wr_p;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_p <= 1'b0;
        else        wr_p <= wr_strobe;
    end

    logic commit_ev;
    assign commit_ev = !direct_mode &&
        ((serial_sel && wr_p && !wr_strobe) || (!serial_sel && !wr_p && wr_strobe));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_ev |=> $stable(ctrl_word));

    p_par_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_mode && !serial_sel && !wr_p && wr_strobe) |=> ctrl_word == $past(pdata));

    p_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_n |-> (pwr_down == ctrl_word[PWR_BIT] && cnt_load == ctrl_word[LOAD_BIT] &&
                    msel_route == ctrl_word[MSEL_BIT] && pre_route == ctrl_word[PRE_BIT] &&
                    fout_oe == ctrl_word[OE_BIT]));

    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        enh_n |-> $countones({pwr_down, cnt_load, msel_route, pre_route, fout_oe}) == 0);

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        direct_mode |=> $stable(ctrl_word));
endmodule

bind enh_ctrl_reg enh_ctrl_reg_chk chk_i (
    .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .serial_sel(serial_sel),
    .wr_strobe(wr_strobe), .pdata(pdata), .enh_n(enh_n), .ctrl_word(ctrl_word),
    .pwr_down(pwr_down), .cnt_load(cnt_load), .msel_route(msel_route),
    .pre_route(pre_route), .fout_oe(fout_oe)
);

// File: tb/enh_ctrl_reg_tb.sv
module enh_ctrl_reg_tb_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       direct_mode = 0, serial_sel = 1, wr_strobe = 0, cnt_wr = 0;
    logic       sdata = 0, sclk = 0, enh_n = 0;
    logic [7:0] pdata = 0;
    logic [7:0] ctrl_word;
    logic       pwr_down, cnt_load, msel_route, pre_route, fout_oe;

    int total = 0, bad = 0;
    logic [7:0] m_stage = 0, m_word = 0;
    logic       finished = 0;

    always #2 clk = ~clk;

    enh_ctrl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .serial_sel(serial_sel),
        .wr_strobe(wr_strobe), .cnt_wr(cnt_wr), .sdata(sdata), .sclk(sclk),
        .pdata(pdata), .enh_n(enh_n), .ctrl_word(ctrl_word), .pwr_down(pwr_down),
        .cnt_load(cnt_load), .msel_route(msel_route), .pre_route(pre_route),
        .fout_oe(fout_oe)
    );

    function automatic logic [4:0] exp_outs(logic [7:0] w, logic en_n);
        return en_n ? 5'b0 : {w[4], w[3], w[2], w[1], w[0]};
    endfunction

    task automatic check(string req);
        logic [4:0] act, exp;
        act = {pwr_down, cnt_load, msel_route, pre_route, fout_oe};
        exp = exp_outs(m_word, enh_n);
        total++;
        if (ctrl_word !== m_word || act !== exp) begin
            bad++;
            $display("FAIL %s: word=%h outs=%b expected word=%h outs=%b",
                     req, ctrl_word, act, m_word, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // shift a byte MSB first; model updates only when shifting is allowed
    task automatic shift_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(); sdata = b[i]; sclk = 1;
            tick(); sclk = 0;
            if (!direct_mode && serial_sel && wr_strobe && !cnt_wr)
                m_stage = {m_stage[6:0], b[i]};
        end
    endtask

    task automatic wr_rise();
        tick(); wr_strobe = 1;
        tick();
        if (!direct_mode && !serial_sel) m_word = pdata;
    endtask

    task automatic wr_fall();
        tick(); wr_strobe = 0;
        tick();
        if (!direct_mode && serial_sel) m_word = m_stage;
    endtask

    task automatic serial_write(logic [7:0] b);
        tick(); serial_sel = 1;
        wr_rise();
        shift_byte(b);
        check("R2 word held during shift");
        wr_fall();
    endtask

    task automatic parallel_write(logic [7:0] b);
        tick(); serial_sel = 0; pdata = b;
        wr_rise();
        wr_fall();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: expected=done actual=hung");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) tick();
        check("R10 reset clears word");
        rst_n = 1;
        tick();
        check("R10 after reset");

        serial_write(8'hA5);
        check("R1/R3 serial MSB-first commit");
        enh_n = 1; tick();
        check("R7 enable high gates outputs");
        enh_n = 0; tick();
        check("R6 output bit map");

        tick(); serial_sel = 1; wr_rise(); wr_fall();
        check("R4 recommit without shifts");

        serial_write(8'hE0);
        check("R10 reserved bits stored, no output effect");

        parallel_write(8'h3C);
        check("R5 parallel load on rising edge");

        tick(); serial_sel = 1; pdata = 8'hFF; wr_rise();
        check("R11 serial-mode rise ignores pdata");
        tick(); cnt_wr = 1; shift_byte(8'h0F); cnt_wr = 0;
        wr_fall();
        check("R9 cnt_wr blocks shift");

        tick(); serial_sel = 1; shift_byte(8'hFF);
        wr_rise(); wr_fall();
        check("R9 wr low blocks shift");

        tick(); serial_sel = 1; wr_rise(); shift_byte(8'h81);
        tick(); serial_sel = 0; wr_fall();
        check("R11 parallel-mode fall does not commit");
        tick(); serial_sel = 1; wr_rise(); wr_fall();
        check("R4 staged data committed later");

        tick(); direct_mode = 1;
        serial_write(8'h5A);
        check("R8 direct mode serial frozen");
        parallel_write(8'hC3);
        check("R8 direct mode parallel frozen");
        tick(); direct_mode = 0; serial_sel = 1; wr_rise(); wr_fall();
        check("R8 staging untouched in direct mode");

        for (int n = 0; n < 300; n++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: serial_write(8'($urandom));
                1: parallel_write(8'($urandom));
                2: begin tick(); enh_n = $urandom_range(0, 1); tick(); end
                3: begin
                    tick(); cnt_wr = 1; serial_sel = 1;
                    wr_rise(); shift_byte(8'($urandom)); cnt_wr = 0; wr_fall();
                end
                default: begin
                    tick(); direct_mode = 1;
                    if ($urandom_range(0, 1) == 1) serial_write(8'($urandom));
                    else parallel_write(8'($urandom));
                    tick(); direct_mode = 0;
                end
            endcase
            check("R1/R3/R5/R6/R7/R8/R9 random op");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule